// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data across in either direction. Each direction has its own storage register with its own capture clock. The A-side register records the A bus. The B-side register records the B bus. A per-direction select picks what the far bus receives: either the live value from the opposite bus, or the value held in that direction's register. An active-low output enable and a direction input decide which bus, if any, the block drives. A parameter chooses a straight or a complementing data path.

Pads are not modelled as tri-state nets. Each bus has a separate input vector, output vector and output-enable flag, so the block can be synthesized. The surrounding pad ring merges the three into a bidirectional pin.

The registers keep capturing while their outputs are disabled. With both outputs off (isolation), both buses can be stored in the same cycle. While one bus is being driven, the other side can still record what is on its own bus.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_n` high, the A-side register takes the value of `a_in`. On each rising edge of `clk_ba` with `rst_n` high, the B-side register takes the value of `b_in`.
- R2: When `rst_n` is low at a rising edge of a capture clock, the register owned by that clock becomes all zeros. The register of the other clock keeps its contents.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R4: While `oe_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0. The two flags are never 1 together.
- R5: `b_out` follows `a_in` combinationally when `sel_ab` = 0. It shows the A-side register when `sel_ab` = 1.
- R6: `a_out` follows `b_in` combinationally when `sel_ba` = 0. It shows the B-side register when `sel_ba` = 1.
- R7: With `INVERT` = 1, every bit of `a_out` and `b_out` is the complement of the value selected in R5 and R6. The registers still hold uncomplemented input data.
- R8: In isolation (`oe_n` = 1), both registers capture on the same edge when both clocks rise together.
- R9: A register keeps capturing from its own bus while the block drives the opposite bus. It also keeps capturing while its own direction is the one being driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-side register |
| clk_ba | input | 1 | Capture clock of the B-side register |
| rst_n | input | 1 | Synchronous active-low clear, sampled by each capture clock |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B from A; 0: drive bus A from B |
| sel_ab | input | 1 | 0: live A data to bus B; 1: stored A data |
| sel_ba | input | 1 | 0: live B data to bus A; 1: stored B data |
| a_in | input | WIDTH | Value sensed on bus A |
| a_out | output | WIDTH | Value offered to bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | WIDTH | Value sensed on bus B |
| b_out | output | WIDTH | Value offered to bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
Two functions can fall in the same cycle. The first is capture, where a register loads on its clock edge. The second is stored-data output, where that same register is selected onto the driven bus. When both happen together, the driven value must change exactly at that edge. This is provoked by pulsing one or both capture clocks while the select reads the register, under every combination of enable, direction and selects. The block is also run in isolation with both clocks rising together. Each result is judged against a bench model that updates its register copies at the same edge and applies the complement per instance.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Which bus the block is driving.
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_TO_A = 2'd1,
    DRV_TO_B = 2'd2
  } drive_e;

  localparam logic DIR_TOWARD_B = 1'b1;

  function automatic drive_e decode_drive(input logic oe_n, input logic dir);
    if (oe_n)
      return DRV_NONE;
    else if (dir == DIR_TOWARD_B)
      return DRV_TO_B;
    else
      return DRV_TO_A;
  endfunction

endpackage

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else
      q <= d;
  end

endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         use_stored,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] path_xform(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  logic [W-1:0] picked;

  always_comb begin
    picked = use_stored ? stored : live;
    y      = path_xform(picked);
  end

endmodule

// File: rtl/bus_xcvr_drive.sv
module bus_xcvr_drive
  import bus_xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);

  drive_e state;

  always_comb begin
    state = decode_drive(oe_n, dir);
    a_oe  = (state == DRV_TO_A);
    b_oe  = (state == DRV_TO_B);
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  // Index 0: A to B path. Index 1: B to A path.
  localparam int NDIR = 2;

  logic             cap_clk  [NDIR];
  logic             use_reg  [NDIR];
  logic [WIDTH-1:0] src_data [NDIR];
  logic [WIDTH-1:0] held     [NDIR];
  logic [WIDTH-1:0] path_y   [NDIR];

  // Named internal state, brought out for the checker.
  logic [WIDTH-1:0] a_store;
  logic [WIDTH-1:0] b_store;

  assign cap_clk[0]  = clk_ab;
  assign cap_clk[1]  = clk_ba;
  assign use_reg[0]  = sel_ab;
  assign use_reg[1]  = sel_ba;
  assign src_data[0] = a_in;
  assign src_data[1] = b_in;

  for (genvar g = 0; g < NDIR; g++) begin : g_path
    bus_xcvr_store #(.W(WIDTH)) u_store (
      .clk   (cap_clk[g]),
      .rst_n (rst_n),
      .d     (src_data[g]),
      .q     (held[g])
    );

    bus_xcvr_path #(.W(WIDTH), .INVERT(INVERT)) u_path (
      .live       (src_data[g]),
      .stored     (held[g]),
      .use_stored (use_reg[g]),
      .y          (path_y[g])
    );
  end

  assign a_store = held[0];
  assign b_store = held[1];
  assign b_out   = path_y[0];
  assign a_out   = path_y[1];

  bus_xcvr_drive u_drive (
    .oe_n (oe_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             rst_n,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_store,
  input logic [WIDTH-1:0] b_store,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_out,
  input logic             a_oe,
  input logic             b_oe
);

  function automatic logic [WIDTH-1:0] expect_path(input logic [WIDTH-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  // R1: capture on each clock
  assert_capture_a_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_n |=> (a_store == $past(a_in)));
  assert_capture_b_R1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_n |=> (b_store == $past(b_in)));

  // R3: isolation drives neither bus
  assert_isolate_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe));

  // R4: enabled output follows direction, never both
  assert_dir_to_b_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir) |-> (b_oe && !a_oe));
  assert_dir_to_a_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir) |-> (a_oe && !b_oe));

  // R5 / R7: B-side output source
  assert_b_live_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !sel_ab |-> (b_out == expect_path(a_in)));
  assert_b_stored_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    sel_ab |-> (b_out == expect_path(a_store)));

  // R6 / R7: A-side output source
  assert_a_live_R6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !sel_ba |-> (a_out == expect_path(b_in)));
  assert_a_stored_R6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    sel_ba |-> (a_out == expect_path(b_store)));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .rst_n   (rst_n),
  .oe_n    (oe_n),
  .dir     (dir),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_store (a_store),
  .b_store (b_store),
  .a_out   (a_out),
  .b_out   (b_out),
  .a_oe    (a_oe),
  .b_oe    (b_oe)
);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic tick = 1'b0;
  always #(CLK_PERIOD/2) tick = ~tick;

  logic         clk_ab = 1'b0;
  logic         clk_ba = 1'b0;
  logic         rst_n  = 1'b0;
  logic         oe_n   = 1'b1;
  logic         dir    = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic [W-1:0] a_in   = '0;
  logic [W-1:0] b_in   = '0;

  logic [W-1:0] a_out_p, b_out_p, a_out_n, b_out_n;
  logic         a_oe_p, b_oe_p, a_oe_n, b_oe_n;

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b0)) u_bus_xcvr_reg (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_p), .a_oe(a_oe_p),
    .b_in(b_in), .b_out(b_out_p), .b_oe(b_oe_p)
  );

  bus_xcvr_reg #(.WIDTH(W), .INVERT(1'b1)) u_bus_xcvr_reg_inv (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out_n), .a_oe(a_oe_n),
    .b_in(b_in), .b_out(b_out_n), .b_oe(b_oe_n)
  );

  // Bench model of the two registers (true data)
  logic [W-1:0] mdl_a = '0;
  logic [W-1:0] mdl_b = '0;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic verify(input string tag_b, input string tag_a);
    logic exp_aoe, exp_boe;
    logic [W-1:0] exp_b, exp_a;
    string oe_tag;
    exp_aoe = !oe_n && !dir;
    exp_boe = !oe_n && dir;
    oe_tag  = oe_n ? "R3" : "R4";
    exp_b   = sel_ab ? mdl_a : a_in;
    exp_a   = sel_ba ? mdl_b : b_in;
    check(oe_tag, "a_oe", {7'b0, a_oe_p}, {7'b0, exp_aoe});
    check(oe_tag, "b_oe", {7'b0, b_oe_p}, {7'b0, exp_boe});
    check(oe_tag, "a_oe inv", {7'b0, a_oe_n}, {7'b0, exp_aoe});
    check(oe_tag, "b_oe inv", {7'b0, b_oe_n}, {7'b0, exp_boe});
    check(tag_b, "b_out", b_out_p, exp_b);
    check(tag_a, "a_out", a_out_p, exp_a);
    check("R7", "b_out inv", b_out_n, ~exp_b);
    check("R7", "a_out inv", a_out_n, ~exp_a);
  endtask

  // Drive one vector; capture clocks rise on the tick's rising edge.
  task automatic apply(input logic oe, input logic d, input logic sa, input logic sb,
                       input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cap_a, input logic cap_b,
                       input string tag_b, input string tag_a);
    @(negedge tick);
    clk_ab = 1'b0; clk_ba = 1'b0;
    oe_n = oe; dir = d; sel_ab = sa; sel_ba = sb; a_in = av; b_in = bv;
    @(posedge tick);
    clk_ab = cap_a; clk_ba = cap_b;
    if (cap_a) mdl_a = rst_n ? av : '0;
    if (cap_b) mdl_b = rst_n ? bv : '0;
    #2;
    verify(tag_b, tag_a);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    // R2: reset clears both registers; read them back through the stored path
    rst_n = 1'b0;
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b1, 1'b1, "R2", "R2");
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b0, 1'b0, "R2", "R2");

    // R1: load each side on its own clock, then hold while inputs move
    apply(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h00, 1'b1, 1'b0, "R1", "R1");
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hC3, 1'b0, 1'b1, "R1", "R1");
    apply(1'b0, 1'b1, 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b0, 1'b0, "R1", "R1");

    // R8: isolation, both clocks together
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 8'h7E, 1'b1, 1'b1, "R8", "R8");
    apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R8", "R8");

    // R9: drive B, capture B side from its own bus; drive A, capture A side
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h12, 8'h9C, 1'b0, 1'b1, "R9", "R9");
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h6D, 8'h44, 1'b1, 1'b0, "R9", "R9");
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R9", "R9");

    // R2: reset owned by one clock only leaves the other register intact
    rst_n = 1'b0;
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hEE, 8'hDD, 1'b1, 1'b0, "R2", "R2");
    rst_n = 1'b1;
    apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h02, 1'b0, 1'b0, "R2", "R2");

    // R5/R6/R3/R4/R7: sweep all control combinations, data and capture patterns
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int k = 0; k < 8; k++) begin
        logic [W-1:0] av, bv;
        logic [3:0] c;
        c  = ctl[3:0];
        av = W'((ctl * 37 + k * 91 + 5) & 255);
        bv = W'(~((k * 53 + ctl * 11) & 255));
        apply(c[0], c[1], c[2], c[3], av, bv, k[0], k[1], "R5", "R6");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule